// File: doc/BRIEF.md
# Row-Neighbour Observation Vector Builder

This block takes the pixel stream that leaves a row-wise transform stage and, for every pixel, builds a small vector of redundant observations for a downstream likelihood generator. The extra observations are the pixels in the same column of nearby rows of the same 8x8 block. Each row comes out of its own row transform, so the hardware errors in different rows are independent. The vertical neighbours can therefore serve as cheap extra noisy copies of the pixel, with no replicated hardware.

Pixels enter in raster order within each block over a valid/ready handshake. A ring of four line buffers keeps the recent rows of the current block. A sequencer releases one vector per pixel, in the same raster order, as soon as every row that vector needs has arrived. A two-bit mode, sampled with the first pixel of each block, selects two, three or four observations. If a needed row lies outside the block, the nearest row inside the block stands in for it, so a vector is always full.

Back-pressure rules: a pixel transfers on a clock edge where `in_valid` and `in_ready` are both high. A vector transfers on an edge where `out_valid` and `out_ready` are both high. Once `out_valid` is raised, it and `out_obs` stay unchanged until the transfer. `in_ready` does not depend on `in_valid`, and `out_valid` does not depend on `out_ready`.

Top module: `rowobs_builder`

## Requirements
- R1: After synchronous reset, `out_valid` is low and `in_ready` is high.
- R2: Pixels are accepted in raster order, 64 per block. The mode is taken from `in_mode` at the acceptance of a block's first pixel: 0 = two observations, 1 = three, 2 = four.
- R3: Each accepted pixel yields exactly one vector, and vectors leave in the same order as the pixels were accepted.
- R4: Element 0 (`out_obs[7:0]`) is always the pixel itself.
- R5: In two-observation mode, element 1 (`out_obs[15:8]`) is the pixel in the same column one row up; row 0 uses itself. Elements 2 and 3 are zero.
- R6: In three-observation mode, element 1 is one row up and element 2 (`out_obs[23:16]`) is one row down. A missing row is replaced by the nearest row of the block (row 0 for above row 0, row 7 for below row 7). Element 3 is zero.
- R7: In four-observation mode, elements 0 to 2 are as in R6, and element 3 (`out_obs[31:24]`) is the same column two rows up, clamped to row 0.
- R8: Mode code 3 behaves exactly as code 2.
- R9: A neighbour is never taken from another block. Row 7 of a block clamps to itself and never uses row 0 of the following block.
- R10: In three- and four-observation modes, the vector for a pixel outside row 7 is not offered before the pixel one row below it, in the same column, has been accepted. In two-observation mode, a vector may be offered once its own pixel is accepted.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_obs` hold their values.
- R12: The first pixel of a block is not accepted until all 64 vectors of the previous block have reached the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pix | input | 8 | Input pixel value |
| in_mode | input | 2 | Observation count select, sampled with the first pixel of a block |
| out_valid | output | 1 | Observation vector valid |
| out_ready | input | 1 | Downstream accepts the vector |
| out_obs | output | 32 | Four 8-bit elements, element i at bits 8i+7..8i |

## Verification
Sixteen blocks are streamed, and every mode code is used on four of them. Each pixel value is a distinct arithmetic function of its block and position. Any element taken from the wrong row, the wrong column or a neighbouring block therefore shows up as a value mismatch against the clamped-neighbour formula. The bench runs four throttle patterns: full rate on both sides, random input gaps, random output stalls, and both at once. These separate data errors from errors in hold behaviour under stalls, in lookahead timing (each vector is compared with how many pixels had been accepted when it left) and in the block hand-over.

// File: rtl/rowobs_pkg.sv
package rowobs_pkg;

  typedef enum logic [1:0] {
    OBS_TWO      = 2'd0,
    OBS_THREE    = 2'd1,
    OBS_FOUR     = 2'd2,
    OBS_FOUR_ALT = 2'd3
  } obs_mode_e;

  // Row offset of each vector element relative to the current row.
  localparam int NUM_ELEM = 4;
  localparam int ELEM_OFS [NUM_ELEM] = '{0, -1, 1, -2};

  function automatic int obs_count(input obs_mode_e m);
    case (m)
      OBS_TWO:   return 2;
      OBS_THREE: return 3;
      default:   return 4;
    endcase
  endfunction

  function automatic int clamp_row(input int r, input int last);
    if (r < 0) return 0;
    if (r > last) return last;
    return r;
  endfunction

endpackage

// File: rtl/rowobs_line_store.sv
module rowobs_line_store #(
  parameter int PIX_W   = 8,
  parameter int BLK     = 8,
  parameter int N_LINES = 4,
  parameter int N_RD    = 4,
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic [COL_W-1:0]        wr_col,
  input  logic [PIX_W-1:0]        wr_pix,
  input  logic [N_RD*ROW_W-1:0]   rd_rows,
  input  logic [COL_W-1:0]        rd_col,
  output logic [N_RD*PIX_W-1:0]   rd_pix
);
  localparam int SLOT_W = $clog2(N_LINES);

  logic [PIX_W-1:0] mem [N_LINES][BLK];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int s = 0; s < N_LINES; s++)
        for (int c = 0; c < BLK; c++)
          mem[s][c] <= '0;
    end else if (wr_en) begin
      mem[wr_row[SLOT_W-1:0]][wr_col] <= wr_pix;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rd_pix[g*PIX_W +: PIX_W] = mem[rd_rows[g*ROW_W +: SLOT_W]][rd_col];
  end

endmodule

// File: rtl/rowobs_gather.sv
module rowobs_gather
  import rowobs_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int ROW_W = 3
) (
  input  obs_mode_e                   mode,
  input  logic [ROW_W-1:0]            cur_row,
  output logic [NUM_ELEM*ROW_W-1:0]   nb_rows,
  input  logic [NUM_ELEM*PIX_W-1:0]   nb_pix,
  output logic [NUM_ELEM*PIX_W-1:0]   vec
);
  int active;
  assign active = obs_count(mode);

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
    assign nb_rows[g*ROW_W +: ROW_W] =
      ROW_W'(clamp_row(int'(cur_row) + ELEM_OFS[g], BLK - 1));
    assign vec[g*PIX_W +: PIX_W] =
      (g < active) ? nb_pix[g*PIX_W +: PIX_W] : '0;
  end

endmodule

// File: rtl/rowobs_seq.sv
module rowobs_seq
  import rowobs_pkg::*;
#(
  parameter int BLK     = 8,
  parameter int N_LINES = 4,
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int CNT_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic             out_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             wr_en,
  output logic [ROW_W-1:0] wr_row,
  output logic [COL_W-1:0] wr_col,
  output logic             rd_fire,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col,
  output logic             blk_done,
  output obs_mode_e        mode_q,
  output logic [CNT_W-1:0] wr_cnt,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam int TOTAL = BLK * BLK;
  localparam logic [CNT_W:0] TOTAL_X = (CNT_W+1)'(TOTAL);
  localparam logic [CNT_W:0] LAG_X   = (CNT_W+1)'(BLK);
  localparam logic [CNT_W:0] HOLD_X  = (CNT_W+1)'((N_LINES - 2) * BLK);
  localparam logic [CNT_W:0] FREE_X  = (CNT_W+1)'(N_LINES * BLK);
  localparam logic [CNT_W:0] LAST_X  = (CNT_W+1)'(TOTAL - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(BLK - 1);

  logic [CNT_W:0] wr_x, rd_x;
  logic           need_ahead, avail;

  assign wr_x = {1'b0, wr_cnt};
  assign rd_x = {1'b0, rd_cnt};

  assign wr_col = wr_cnt[COL_W-1:0];
  assign wr_row = wr_cnt[COL_W +: ROW_W];
  assign rd_col = rd_cnt[COL_W-1:0];
  assign rd_row = rd_cnt[COL_W +: ROW_W];

  // A new row may overwrite its ring slot only after every vector that
  // still reads the old row has been issued.
  assign in_ready = (wr_x < TOTAL_X) && ((wr_x < FREE_X) || (rd_x + HOLD_X > wr_x));
  assign wr_en    = in_valid && in_ready;

  assign need_ahead = (obs_count(mode_q) > 2) && (rd_row != LAST_ROW);
  assign avail      = (rd_x < TOTAL_X) &&
                      (need_ahead ? (wr_x > rd_x + LAG_X) : (wr_x > rd_x));
  assign rd_fire    = avail && (!out_valid || out_ready);
  assign blk_done   = rd_fire && (rd_x == LAST_X);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
      mode_q <= OBS_TWO;
    end else begin
      if (blk_done) begin
        wr_cnt <= '0;
        rd_cnt <= '0;
      end else begin
        if (wr_en)   wr_cnt <= wr_cnt + 1'b1;
        if (rd_fire) rd_cnt <= rd_cnt + 1'b1;
      end
      if (wr_en && (wr_cnt == '0)) mode_q <= obs_mode_e'(in_mode);
    end
  end

endmodule

// File: rtl/rowobs_builder.sv
module rowobs_builder
  import rowobs_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [PIX_W-1:0]          in_pix,
  input  logic [1:0]                in_mode,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [4*PIX_W-1:0]        out_obs
);
  localparam int N_LINES = 4;
  localparam int ROW_W   = $clog2(BLK);
  localparam int COL_W   = $clog2(BLK);
  localparam int CNT_W   = $clog2(BLK * BLK + 1);

  logic             wr_en, rd_fire, blk_done;
  logic [ROW_W-1:0] wr_row, rd_row;
  logic [COL_W-1:0] wr_col, rd_col;
  logic [CNT_W-1:0] wr_cnt, rd_cnt;
  obs_mode_e        mode_q;

  logic [NUM_ELEM*ROW_W-1:0] nb_rows;
  logic [NUM_ELEM*PIX_W-1:0] nb_pix, vec;

  rowobs_seq #(
    .BLK(BLK), .N_LINES(N_LINES), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .in_ready(in_ready),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .rd_fire(rd_fire), .rd_row(rd_row), .rd_col(rd_col),
    .blk_done(blk_done), .mode_q(mode_q), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt)
  );

  rowobs_line_store #(
    .PIX_W(PIX_W), .BLK(BLK), .N_LINES(N_LINES), .N_RD(NUM_ELEM),
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_store (
    .clk(clk), .rst(rst), .clr(blk_done), .wr_en(wr_en),
    .wr_row(wr_row), .wr_col(wr_col), .wr_pix(in_pix),
    .rd_rows(nb_rows), .rd_col(rd_col), .rd_pix(nb_pix)
  );

  rowobs_gather #(
    .PIX_W(PIX_W), .BLK(BLK), .ROW_W(ROW_W)
  ) u_gather (
    .mode(mode_q), .cur_row(rd_row), .nb_rows(nb_rows),
    .nb_pix(nb_pix), .vec(vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_obs   <= '0;
    end else if (rd_fire) begin
      out_valid <= 1'b1;
      out_obs   <= vec;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rowobs_builder_chk.sv
module rowobs_builder_chk
  import rowobs_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int ROW_W = 3,
  parameter int CNT_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               out_valid,
  input logic               out_ready,
  input logic [4*PIX_W-1:0] out_obs,
  input logic               rd_fire,
  input logic [ROW_W-1:0]   rd_row,
  input logic [CNT_W-1:0]   wr_cnt,
  input logic [CNT_W-1:0]   rd_cnt,
  input obs_mode_e          mode_q
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(BLK - 1);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_obs)); // R11

  AST_RD_BEHIND_WR: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= wr_cnt); // R3

  AST_BLOCK_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(wr_cnt) <= BLK * BLK); // R2

  AST_LOOKAHEAD: assert property (@(posedge clk) disable iff (rst)
    rd_fire && (mode_q != OBS_TWO) && (rd_row != LAST_ROW)
      |-> int'(wr_cnt) >= int'(rd_cnt) + BLK + 1); // R10

  AST_TWO_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_fire && (mode_q == OBS_TWO) |=> out_obs[4*PIX_W-1:2*PIX_W] == '0); // R5

endmodule

bind rowobs_builder rowobs_builder_chk #(
  .PIX_W(PIX_W), .BLK(BLK), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_obs(out_obs), .rd_fire(rd_fire), .rd_row(rd_row),
  .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .mode_q(mode_q)
);

// File: tb/rowobs_builder_bench.sv
`timescale 1ns/1ps
module rowobs_builder_bench;
  localparam int NBLK  = 16;
  localparam int NPIX  = 64;
  localparam int TOTAL = NBLK * NPIX;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_pix;
  logic [1:0]  in_mode;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_obs;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rowobs_builder u_rowobs_builder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_obs(out_obs)
  );

  function automatic logic [7:0] pix(input int b, input int k);
    return 8'((b * 53 + k * 29 + 7) % 256);
  endfunction

  function automatic int clampr(input int r);
    if (r < 0) return 0;
    if (r > 7) return 7;
    return r;
  endfunction

  // Expected vector from R4..R9: offsets 0,-1,+1,-2 rows, clamped in block.
  function automatic logic [31:0] exp_vec(input int b, input int k);
    int m, cnt, r, c;
    int ofs [4] = '{0, -1, 1, -2};
    logic [31:0] v;
    m   = b % 4;
    cnt = (m == 0) ? 2 : (m == 1) ? 3 : 4;
    r   = k / 8;
    c   = k % 8;
    v   = '0;
    for (int i = 0; i < 4; i++)
      if (i < cnt) v[i*8 +: 8] = pix(b, clampr(r + ofs[i]) * 8 + c);
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    int in_k, out_k, cyc, ob, ok_k, need, issued, ph_in, ph_out;
    logic [15:0] lfsr;
    string tag;
    in_k = 0; out_k = 0; cyc = 0; lfsr = 16'hACE1;
    rst = 1'b1; in_valid = 1'b0; in_pix = '0; in_mode = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle state while reset is held and right after release
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    while (out_k < TOTAL) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(1'b0, "watchdog R3", out_k, TOTAL);
        break;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ph_in  = (in_k / NPIX) / 4;
      ph_out = (out_k / NPIX) / 4;
      in_valid  = (in_k < TOTAL) && ((ph_in == 1 || ph_in == 3) ? lfsr[0] : 1'b1);
      in_pix    = pix(in_k / NPIX, in_k % NPIX);
      in_mode   = 2'((in_k / NPIX) % 4);
      out_ready = (ph_out == 2 || ph_out == 3) ? lfsr[5] : 1'b1;
      #1;
      // R12: next block starts only after previous block's vectors are issued
      if (in_valid && in_ready && (in_k % NPIX == 0) && in_k > 0) begin
        issued = out_k + (out_valid ? 1 : 0);
        check(issued >= in_k, "R12 block hand-over", issued, in_k);
      end
      if (out_valid && out_ready) begin
        ob   = out_k / NPIX;
        ok_k = out_k % NPIX;
        case (ob % 4)
          0: tag = "R3 R4 R5";
          1: tag = "R3 R4 R6";
          2: tag = "R3 R4 R7 R2";
          default: tag = "R3 R4 R8";
        endcase
        if (ok_k >= 56 && ob % 4 != 0) tag = {tag, " R9"};
        check(out_obs == exp_vec(ob, ok_k), tag, int'(out_obs), int'(exp_vec(ob, ok_k)));
        // R10: lookahead of one row in modes three and four
        need = ob * NPIX + (((ob % 4) != 0 && ok_k / 8 < 7) ? ok_k + 9 : ok_k + 1);
        check(in_k >= need, "R10 lookahead", in_k, need);
        out_k++;
      end
      if (in_valid && in_ready) in_k++;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule